// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is the target side of an I2C serial EEPROM. It runs in the system clock domain. The bus clock and the bus data input are oversampled through synchronizers. The block drives the data line only through an open-drain output enable, so its own driven value is always low. A master addresses it with a select byte. The select byte holds a four-bit type code, three bits that must match the chip enable pins, and a direction bit. A write then carries a two-byte word address followed by one or more data bytes. A read returns bytes from the current address and advances the address after every byte.

Written bytes are collected in a page buffer of 64 entries. They are copied into the byte array only after the STOP that ends the write. That copy runs inside a timed busy window. During the window the block refuses to acknowledge its select byte, so a master can poll until programming is complete. A write control input blocks programming completely.

The array depth is set by `ADDR_W`. The default is 10, which gives 1024 bytes. With `ADDR_W = 15` the array holds 32768 bytes. The address width is independent of the bus format, which always carries 16 address bits.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the SDA output enable `sda_oe_o` is 0. The block drives nothing until it is addressed.
- R2: The select byte holds the type code 1010 in bits 7:4, the chip enable match in bits 3:1 and the direction in bit 0, where 1 means read. The block acknowledges the select byte, by driving SDA low in the ninth clock, only when bits 7:4 are 1010 and bits 3:1 equal `ce_i`. Any other select byte is left unacknowledged.
- R3: After a write select, the block acknowledges two address bytes. The high byte comes first. The word address is the low `ADDR_W` bits of the 16-bit value, and the higher bits are ignored.
- R4: A byte written to an address and followed by STOP reads back from that address in a later random read. A random read is a write select, two address bytes, a repeated START and a read select.
- R5: During a write the low 6 address bits advance and wrap inside the current 64-byte page. Data bytes beyond 64 overwrite earlier bytes of the same page. The following page is left untouched.
- R6: A read sends the byte at the current address and then increments the address. While the master acknowledges, further bytes follow. The address rolls over from the last address to 0.
- R7: A read ended by a master NACK and a STOP leaves the address one past the last byte sent. A current-address read, which is a read select with no address phase, starts there.
- R8: While `wc_i` is 1, data bytes are not acknowledged and the array is unchanged. The select byte and address bytes are still acknowledged, and no busy window starts.
- R9: A STOP that ends a write with at least one accepted data byte starts a busy window of `BUSY_CYCLES` clocks. During the window every select byte is left unacknowledged. After the window, select bytes are acknowledged again.
- R10: The block changes `sda_oe_o` only while SCL is low.
- R11: A write that ends after the address bytes, with no data, sets the current address but starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| ce_i | input | 3 | Chip enable pins, compared with select bits 3:1 |
| wc_i | input | 1 | Write control; 1 blocks programming |

## Verification
The bench writes 66 bytes starting two bytes before the end of a page. It then reads back the wrapped offsets and the first byte of the next page. A design that carried the address into the next page, or kept the first bytes instead of the last ones, returns the wrong bytes.

The bench polls with a select byte immediately after a write STOP, and again after the window. A design without the busy window acknowledges too early; one with a stuck window never acknowledges again. The bench also checks that address-only writes and write-protected writes leave the next select acknowledged at once.

A sequential read crosses the last address, and a current-address read follows the NACK. These catch a missing rollover or an address that is not advanced after the final byte. Select bytes with a wrong chip enable or a wrong type code must stay unacknowledged.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } ee_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } ee_kind_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] line_in;
  logic [1:0] line_q;
  logic [1:0] line_d;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain     <= '1;
        line_d[g] <= 1'b1;
      end else begin
        chain     <= {chain[STAGES-2:0], line_in[g]};
        line_d[g] <= chain[STAGES-1];
      end
    end
    assign line_q[g] = chain[STAGES-1];
  end

  assign scl_s     = line_q[0];
  assign sda_s     = line_q[1];
  assign scl_rise  = line_q[0] & ~line_d[0];
  assign scl_fall  = ~line_q[0] & line_d[0];
  assign start_det = line_q[0] & line_d[0] & line_d[1] & ~line_q[1];
  assign stop_det  = line_q[0] & line_d[0] & ~line_d[1] & line_q[1];
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_data,
  input  logic                     buf_clr,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  input  logic                     commit_go,
  output logic                     busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int BCW   = $clog2(BUSY_CYCLES + 1);

  logic [7:0]               mem  [DEPTH];
  logic [7:0]               pbuf [PAGE];
  logic [PAGE-1:0]          pmask;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic [PAGE_W-1:0]        cidx;
  logic                     committing;
  logic [BCW-1:0]           bcnt;

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (rst || buf_clr) pmask <= '0;
    else if (buf_we)    pmask[buf_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      committing <= 1'b0;
      cidx       <= '0;
      bcnt       <= '0;
      base_q     <= '0;
    end else if (commit_go) begin
      busy       <= 1'b1;
      committing <= 1'b1;
      cidx       <= '0;
      bcnt       <= BCW'(BUSY_CYCLES - 1);
      base_q     <= page_base;
    end else if (busy) begin
      if (bcnt == '0) busy <= 1'b0;
      else            bcnt <= bcnt - 1'b1;
      if (committing) begin
        cidx <= cidx + 1'b1;
        if (cidx == '1) committing <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (committing && pmask[cidx]) mem[{base_q, cidx}] <= pbuf[cidx];
    rd_data <= mem[rd_addr];
  end

  AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    committing |-> busy); // R9
  AST_NO_BUFWR_BUSY: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !busy); // R9
endmodule

// File: rtl/i2c_ee_fsm.sv
module i2c_ee_fsm
  import i2c_ee_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         PAGE_W    = 6,
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl_s,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic [2:0]               ce_i,
  input  logic                     wc_i,
  input  logic                     busy,
  input  logic [7:0]               rd_data,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     buf_we,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic [7:0]               buf_data,
  output logic                     buf_clr,
  output logic [ADDR_W-PAGE_W-1:0] page_base,
  output logic                     commit_go,
  output logic                     sda_oe
);
  localparam logic [ADDR_W-1:0] ONE_A = 1;
  localparam logic [PAGE_W-1:0] ONE_P = 1;

  ee_state_t          state;
  ee_kind_t           kind, nxt_kind;
  logic [3:0]         cnt;
  logic [7:0]         sr, tx_sr, addr_hi;
  logic [ADDR_W-1:0]  cur_addr;
  logic               rw, wr_pend, mack_ok;
  logic               byte_done, dev_match;
  logic [15:0]        word;
  logic               unused_hi;

  assign word      = {addr_hi, sr};
  assign unused_hi = ^word[15:ADDR_W];
  assign byte_done = (state == ST_RX) && (cnt == 4'd8) && scl_fall;
  assign dev_match = (sr[7:4] == TYPE_CODE) && (sr[3:1] == ce_i) && !busy;
  assign buf_we    = byte_done && (kind == K_DATA) && !wc_i;
  assign buf_idx   = cur_addr[PAGE_W-1:0];
  assign buf_data  = sr;
  assign buf_clr   = byte_done && (kind == K_ALO);
  assign commit_go = stop_det && wr_pend;
  assign page_base = cur_addr[ADDR_W-1:PAGE_W];
  assign rd_addr   = cur_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= K_DEV;
      nxt_kind <= K_DEV;
      cnt      <= '0;
      sr       <= '0;
      tx_sr    <= '0;
      addr_hi  <= '0;
      cur_addr <= '0;
      rw       <= 1'b0;
      wr_pend  <= 1'b0;
      mack_ok  <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_RX;
      kind   <= K_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            state  <= ST_ACK;
            sda_oe <= 1'b1;
            case (kind)
              K_DEV: begin
                if (!dev_match) begin
                  state  <= ST_IDLE;
                  sda_oe <= 1'b0;
                end else begin
                  rw       <= sr[0];
                  nxt_kind <= K_AHI;
                end
              end
              K_AHI: begin
                addr_hi  <= sr;
                nxt_kind <= K_ALO;
              end
              K_ALO: begin
                cur_addr <= word[ADDR_W-1:0];
                nxt_kind <= K_DATA;
              end
              default: begin
                if (wc_i) begin
                  state  <= ST_IDLE;
                  sda_oe <= 1'b0;
                end else begin
                  cur_addr <= {cur_addr[ADDR_W-1:PAGE_W], cur_addr[PAGE_W-1:0] + ONE_P};
                  wr_pend  <= 1'b1;
                  nxt_kind <= K_DATA;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (kind == K_DEV && rw) begin
              state  <= ST_TX;
              tx_sr  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state  <= ST_RX;
              kind   <= nxt_kind;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              state    <= ST_MACK;
              sda_oe   <= 1'b0;
              cur_addr <= cur_addr + ONE_A;
            end else begin
              cnt    <= cnt + 4'd1;
              tx_sr  <= {tx_sr[6:0], 1'b0};
              sda_oe <= ~tx_sr[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_ok) begin
              state  <= ST_TX;
              cnt    <= '0;
              tx_sr  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R10
  AST_BUSY_SELECT_NACK: assert property (@(posedge clk) disable iff (rst)
    (byte_done && kind == K_DEV && busy) |=> !sda_oe); // R9
  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (rst)
    buf_we |=> $stable(cur_addr[ADDR_W-1:PAGE_W])); // R5
  AST_WC_DATA_NACK: assert property (@(posedge clk) disable iff (rst)
    (byte_done && kind == K_DATA && wc_i) |=> (!sda_oe && state == ST_IDLE)); // R8
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int         ADDR_W      = 10,
  parameter int         PAGE_W      = 6,
  parameter int         BUSY_CYCLES = 2000,
  parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] ce_i,
  input  logic       wc_i
);
  logic                     scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                     busy, buf_we, buf_clr, commit_go;
  logic [7:0]               rd_data, buf_data;
  logic [ADDR_W-1:0]        rd_addr;
  logic [PAGE_W-1:0]        buf_idx;
  logic [ADDR_W-PAGE_W-1:0] page_base;

  i2c_ee_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ee_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TYPE_CODE(TYPE_CODE)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .ce_i(ce_i), .wc_i(wc_i), .busy(busy), .rd_data(rd_data),
    .rd_addr(rd_addr), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .buf_clr(buf_clr), .page_base(page_base), .commit_go(commit_go),
    .sda_oe(sda_oe_o)
  );

  i2c_ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data), .buf_clr(buf_clr),
    .page_base(page_base), .commit_go(commit_go), .busy(busy)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sda_oe_o); // R1
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb_top;
  localparam int AW   = 10;
  localparam int BUSY = 2000;
  localparam logic [2:0] CE = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wc = 1'b0;
  logic sda_oe_o;
  logic sda_line;
  int   qtr = 625;
  int   n_run = 0;
  int   n_fail = 0;
  int   r10_viol = 0;
  logic oe_prev = 1'b0;
  bit   done = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  int    act_q[$];
  int    rd_exp[0:7];
  logic [7:0] wbuf[0:79];

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe_o;

  i2c_eeprom_target #(.ADDR_W(AW), .PAGE_W(6), .BUSY_CYCLES(BUSY), .TYPE_CODE(4'b1010)) dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .ce_i(CE), .wc_i(wc)
  );

  // monitor: pops expected items and compares them with observed ones
  initial begin
    forever begin
      @(negedge clk);
      if (m_scl && (sda_oe_o != oe_prev)) r10_viol++;
      oe_prev = sda_oe_o;
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        int a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (a != e) begin
          n_fail++;
          $display("FAIL %s actual=%0h expected=%0h", t, a, e);
        end
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
    end
  end

  task automatic expect_v(input string t, input int v);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; #qtr; m_scl = 1'b1; #qtr; m_sda = 1'b0; #qtr; m_scl = 1'b0; #qtr;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #qtr; m_scl = 1'b1; #qtr; m_sda = 1'b1; #qtr;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      m_sda = v[i]; #qtr; m_scl = 1'b1; #(2*qtr); m_scl = 1'b0; #qtr;
    end
    m_sda = 1'b1; #qtr; m_scl = 1'b1; #qtr;
    act_q.push_back(int'(sda_line));
    #qtr; m_scl = 1'b0; #qtr;
  endtask

  task automatic recv_byte(input bit nack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; #qtr; m_scl = 1'b1; #qtr; v[i] = sda_line; #qtr; m_scl = 1'b0; #qtr;
    end
    m_sda = nack; #qtr; m_scl = 1'b1; #(2*qtr); m_scl = 1'b0; #qtr;
    act_q.push_back(int'(v));
  endtask

  function automatic logic [7:0] dev(input logic [3:0] ty, input logic [2:0] c, input bit rd);
    return {ty, c, rd};
  endfunction

  task automatic sel(input bit rd, input int ack, input string t);
    bus_start();
    expect_v(t, ack);
    send_byte(dev(4'b1010, CE, rd));
  endtask

  task automatic write_seq(input int addr, input int n, input int data_ack, input string t);
    sel(1'b0, 0, t);
    expect_v(t, 0); send_byte(8'(addr >> 8));
    expect_v(t, 0); send_byte(8'(addr));
    for (int k = 0; k < n; k++) begin
      expect_v(t, data_ack);
      send_byte(wbuf[k]);
    end
    bus_stop();
  endtask

  task automatic rand_read(input int addr, input int n, input string t);
    sel(1'b0, 0, t);
    expect_v(t, 0); send_byte(8'(addr >> 8));
    expect_v(t, 0); send_byte(8'(addr));
    sel(1'b1, 0, t);
    for (int k = 0; k < n; k++) begin
      expect_v(t, rd_exp[k]);
      recv_byte(k == n - 1);
    end
    bus_stop();
  endtask

  task automatic wait_busy();
    #((BUSY + 100) * 20);
  endtask

  function automatic logic [7:0] pd(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    expect_v("R1 oe after reset", 0);
    act_q.push_back(int'(sda_oe_o));
    #1000;

    // R2: chip enable mismatch and wrong type code are ignored
    bus_start(); expect_v("R2 wrong chip enable", 1);
    send_byte(dev(4'b1010, 3'b100, 1'b0)); bus_stop();
    bus_start(); expect_v("R2 wrong type code", 1);
    send_byte(dev(4'b1011, CE, 1'b0)); bus_stop();

    // R3 R4: byte write with ignored high address bit, R9 busy window
    wbuf[0] = 8'hA7;
    write_seq(16'h8123, 1, 0, "R3 byte write 0x123");
    sel(1'b0, 1, "R9 select during busy"); bus_stop();
    wait_busy();
    sel(1'b0, 0, "R9 select after busy"); bus_stop();
    wbuf[0] = 8'h5A;
    write_seq(16'h0240, 1, 0, "R4 marker write 0x240");
    wait_busy();
    rd_exp[0] = 8'hA7;
    rand_read(16'h0123, 1, "R4 readback 0x123");

    // R5: 66 bytes from offset 62 wrap inside page 0x200
    qtr = 200;
    for (int k = 0; k < 66; k++) wbuf[k] = pd(k);
    write_seq(16'h023E, 66, 0, "R5 page write");
    wait_busy();
    rd_exp[0] = pd(64); rd_exp[1] = pd(65); rd_exp[2] = 8'h5A;
    rand_read(16'h023E, 3, "R5 wrap tail and next page");
    rd_exp[0] = pd(2);
    rand_read(16'h0200, 1, "R5 page offset 0");
    rd_exp[0] = pd(63);
    rand_read(16'h023D, 1, "R5 page offset 61");

    // R8: write control blocks data, no busy window follows
    wc = 1'b1;
    wbuf[0] = 8'h77;
    write_seq(16'h0123, 1, 1, "R8 protected write");
    sel(1'b0, 0, "R8 no busy after protected write"); bus_stop();
    wc = 1'b0;
    rd_exp[0] = 8'hA7;
    rand_read(16'h0123, 1, "R8 array unchanged");

    // R6 R7: rollover from the last address, then current-address read
    wbuf[0] = 8'hEE;
    write_seq(16'h03FF, 1, 0, "R6 write last address");
    wait_busy();
    wbuf[0] = 8'h31; wbuf[1] = 8'h32;
    write_seq(16'h0000, 2, 0, "R6 write address 0");
    wait_busy();
    rd_exp[0] = 8'hEE; rd_exp[1] = 8'h31;
    rand_read(16'h03FF, 2, "R6 sequential rollover");
    sel(1'b1, 0, "R7 current-address read");
    expect_v("R7 current-address data", 8'h32);
    recv_byte(1'b1); bus_stop();

    // R11: address-only write then immediate current-address read
    sel(1'b0, 0, "R11 address-only write");
    expect_v("R11 addr hi", 0); send_byte(8'h01);
    expect_v("R11 addr lo", 0); send_byte(8'h23);
    bus_stop();
    sel(1'b1, 0, "R11 select right after stop");
    expect_v("R11 data at set address", 8'hA7);
    recv_byte(1'b1); bus_stop();

    #2000;
    @(negedge clk);
    @(negedge clk);
    expect_v("R10 oe changes with SCL high", 0);
    act_q.push_back(r10_viol);
    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++;
      n_fail++;
      $display("FAIL scoreboard residue actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule